// File: doc/BRIEF.md
# Multidrop Address-Match Serial Receiver

This block is the receive side of a node on a shared serial bus. A single controller talks to many nodes over one line. Every character carries a ninth bit beside the eight payload bits. That bit tells the nodes whether the payload is a node address or ordinary data. The receiver oversamples the line, rebuilds each character and compares address characters with the node's own identity. It keeps one bit of state that records whether this node is the current conversation partner.

Address characters always interrupt the local processor, so every node can follow who is being addressed. Data characters interrupt only the node that is currently selected, and the other nodes never see that traffic. A reserved data value closes the conversation: the selected node takes that byte with an interrupt and then drops its selection. A character whose stop bit is wrong is discarded and reported on a separate strobe, and it leaves the selection as it was.

The node identity, the closing code, the oversampling ratio and the clock divider are parameters. With the default divider and a 125 MHz clock the line runs near 57.6 kbaud.

Top module: `mdrx_node`

## Requirements
- R1: A character is 11 bit periods long: a start bit at 0, eight payload bits least significant first, a flag bit, then a stop bit at 1. One bit period is OVERSAMPLE*CLKS_PER_TICK clock cycles, and every bit is sampled near its middle.
- R2: A low level on an idle line is taken as a start bit only if it is still low half a bit period later. A shorter low pulse produces neither an interrupt nor a framing error.
- R3: A character with flag bit 1 is an address. It always produces an interrupt, with `rx_byte` equal to the address and `rx_is_addr` equal to 1.
- R4: After an address character, `selected` is 1 if the address equals NODE_ID and 0 otherwise. A non-matching address therefore drops an existing selection.
- R5: A character with flag bit 0 is data. While the node is selected, it produces an interrupt, with `rx_byte` equal to the data and `rx_is_addr` equal to 0.
- R6: A data character that arrives while the node is not selected produces no interrupt and leaves `rx_byte`, `rx_is_addr` and `selected` unchanged.
- R7: A data character equal to EOC_CODE that arrives while the node is selected produces its interrupt and clears `selected` in the same cycle.
- R8: A character whose stop bit is sampled at 0 produces a one-cycle `frame_err` pulse. It produces no interrupt and leaves `selected` unchanged, whether its flag marks an address or data.
- R9: While reset is held, `rx_irq`, `frame_err`, `selected`, `rx_is_addr` and `rx_byte` are all 0.
- R10: `rx_irq` is a pulse one clock cycle wide for each accepted character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Asynchronous serial line, idle at 1 |
| rx_byte | output | 8 | Payload of the last accepted character |
| rx_is_addr | output | 1 | Flag bit of the last accepted character |
| rx_irq | output | 1 | One-cycle receive interrupt |
| frame_err | output | 1 | One-cycle pulse on a bad stop bit |
| selected | output | 1 | Node is currently addressed |

## Verification
The checker watches every cycle for the following: the interrupt stays a single cycle wide, the selection never changes without an interrupt, and an address interrupt leaves `selected` equal to the result of the identity compare. It also checks that a data interrupt happens only with the node already selected, that the closing code leaves the node deselected, and that a framing error is never followed by an interrupt. Only the bench scenarios can show that the payload bits come out in the right order and that every address value selects or deselects correctly. The same holds for data being withheld from a node that was not addressed, for a short glitch being rejected as a start bit, and for a framing error leaving the selection in place.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;

    localparam int PAYLOAD_W = 8;
    localparam int SHIFT_W   = PAYLOAD_W + 1;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic                 is_addr;
        logic [PAYLOAD_W-1:0] payload;
    } rx_frame_t;

    function automatic rx_frame_t unpack_shift(input logic [SHIFT_W-1:0] sh);
        rx_frame_t f;
        f.is_addr = sh[SHIFT_W-1];
        f.payload = sh[PAYLOAD_W-1:0];
        return f;
    endfunction

endpackage

// File: rtl/mdrx_sync.sv
module mdrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mdrx_deser.sv
module mdrx_deser
    import mdrx_pkg::*;
#(
    parameter int OVERSAMPLE    = 16,
    parameter int CLKS_PER_TICK = 136
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rx,
    output logic      frame_valid,
    output rx_frame_t frame_o,
    output logic      frame_err
);
    localparam int TICK_W = $clog2(CLKS_PER_TICK + 1);
    localparam int OS_W   = $clog2(OVERSAMPLE + 1);
    localparam int IDX_W  = $clog2(SHIFT_W + 1);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CLKS_PER_TICK - 1);
    localparam logic [OS_W-1:0]   OS_LAST   = OS_W'(OVERSAMPLE - 1);
    localparam logic [OS_W-1:0]   OS_HALF   = OS_W'(OVERSAMPLE / 2 - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(SHIFT_W - 1);

    logic [TICK_W-1:0]  div_q;
    logic               tick;
    rx_state_e          state_q;
    logic [OS_W-1:0]    os_q;
    logic [IDX_W-1:0]   idx_q;
    logic [SHIFT_W-1:0] shift_q;

    assign tick = (div_q == TICK_LAST);

    always_ff @(posedge clk) begin
        if (rst || tick) div_q <= '0;
        else             div_q <= div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= RX_IDLE;
            os_q        <= '0;
            idx_q       <= '0;
            shift_q     <= '0;
            frame_valid <= 1'b0;
            frame_err   <= 1'b0;
        end else begin
            frame_valid <= 1'b0;
            frame_err   <= 1'b0;
            if (tick) begin
                case (state_q)
                    RX_IDLE: begin
                        if (!rx) begin
                            state_q <= RX_START;
                            os_q    <= '0;
                        end
                    end
                    RX_START: begin
                        if (os_q == OS_HALF) begin
                            os_q    <= '0;
                            idx_q   <= '0;
                            state_q <= rx ? RX_IDLE : RX_BITS;
                        end else begin
                            os_q <= os_q + 1'b1;
                        end
                    end
                    RX_BITS: begin
                        if (os_q == OS_LAST) begin
                            os_q    <= '0;
                            shift_q <= {rx, shift_q[SHIFT_W-1:1]};
                            if (idx_q == IDX_LAST) state_q <= RX_STOP;
                            else                   idx_q   <= idx_q + 1'b1;
                        end else begin
                            os_q <= os_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (os_q == OS_LAST) begin
                            os_q        <= '0;
                            state_q     <= RX_IDLE;
                            frame_valid <= rx;
                            frame_err   <= !rx;
                        end else begin
                            os_q <= os_q + 1'b1;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign frame_o = unpack_shift(shift_q);
endmodule

// File: rtl/mdrx_select.sv
module mdrx_select
    import mdrx_pkg::*;
#(
    parameter logic [PAYLOAD_W-1:0] NODE_ID  = 8'h01,
    parameter logic [PAYLOAD_W-1:0] EOC_CODE = 8'h04
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_valid,
    input  rx_frame_t            frame_i,
    output logic                 irq,
    output logic [PAYLOAD_W-1:0] byte_o,
    output logic                 is_addr_o,
    output logic                 selected_o
);
    logic accept;

    assign accept = frame_valid && (frame_i.is_addr || selected_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq        <= 1'b0;
            byte_o     <= '0;
            is_addr_o  <= 1'b0;
            selected_o <= 1'b0;
        end else begin
            irq <= accept;
            if (accept) begin
                byte_o    <= frame_i.payload;
                is_addr_o <= frame_i.is_addr;
                if (frame_i.is_addr)
                    selected_o <= (frame_i.payload == NODE_ID);
                else if (frame_i.payload == EOC_CODE)
                    selected_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mdrx_node.sv
module mdrx_node
    import mdrx_pkg::*;
#(
    parameter int                   OVERSAMPLE    = 16,
    parameter int                   CLKS_PER_TICK = 136,
    parameter logic [PAYLOAD_W-1:0] NODE_ID       = 8'h01,
    parameter logic [PAYLOAD_W-1:0] EOC_CODE      = 8'h04
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rxd,
    output logic [PAYLOAD_W-1:0] rx_byte,
    output logic                 rx_is_addr,
    output logic                 rx_irq,
    output logic                 frame_err,
    output logic                 selected
);
    logic      rx_s;
    logic      f_valid;
    rx_frame_t f_data;

    mdrx_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rx_s)
    );

    mdrx_deser #(
        .OVERSAMPLE    (OVERSAMPLE),
        .CLKS_PER_TICK (CLKS_PER_TICK)
    ) u_deser (
        .clk         (clk),
        .rst         (rst),
        .rx          (rx_s),
        .frame_valid (f_valid),
        .frame_o     (f_data),
        .frame_err   (frame_err)
    );

    mdrx_select #(
        .NODE_ID  (NODE_ID),
        .EOC_CODE (EOC_CODE)
    ) u_select (
        .clk         (clk),
        .rst         (rst),
        .frame_valid (f_valid),
        .frame_i     (f_data),
        .irq         (rx_irq),
        .byte_o      (rx_byte),
        .is_addr_o   (rx_is_addr),
        .selected_o  (selected)
    );
endmodule

// File: rtl/mdrx_node_chk.sv
module mdrx_node_chk #(
    parameter logic [7:0] NODE_ID  = 8'h01,
    parameter logic [7:0] EOC_CODE = 8'h04
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] rx_byte,
    input logic       rx_is_addr,
    input logic       rx_irq,
    input logic       frame_err,
    input logic       selected
);
    // R10: interrupt is one cycle wide
    p_irq_single_r10: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq);

    // R4: address interrupt leaves selection equal to the identity compare
    p_addr_select_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_irq && rx_is_addr) |-> (selected == (rx_byte == NODE_ID)));

    // R5 / R6: a data interrupt requires prior selection
    p_data_needs_sel_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_irq && !rx_is_addr) |-> $past(selected));

    // R7: closing code leaves the node deselected
    p_eoc_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_irq && !rx_is_addr && rx_byte == EOC_CODE) |-> !selected);

    // R8: selection moves only together with an interrupt
    p_sel_moves_with_irq_r8: assert property (@(posedge clk) disable iff (rst)
        (selected != $past(selected)) |-> rx_irq);

    // R8: framing error is not followed by an interrupt
    p_err_no_irq_r8: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !rx_irq);

    // R8: the two strobes never coincide
    p_err_irq_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(frame_err && rx_irq));
endmodule

bind mdrx_node mdrx_node_chk #(
    .NODE_ID  (NODE_ID),
    .EOC_CODE (EOC_CODE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_byte    (rx_byte),
    .rx_is_addr (rx_is_addr),
    .rx_irq     (rx_irq),
    .frame_err  (frame_err),
    .selected   (selected)
);

// File: tb/tb_mdrx_node.sv
module tb_mdrx_node;
    localparam int         OS   = 16;
    localparam int         TPC  = 1;
    localparam int         BIT  = OS * TPC;
    localparam logic [7:0] ID   = 8'h5A;
    localparam logic [7:0] EOC  = 8'h04;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_is_addr, rx_irq, frame_err, selected;

    int total = 0;
    int bad   = 0;
    int irq_cnt = 0;
    int err_cnt = 0;
    int wide_irq = 0;
    logic prev_irq = 1'b0;

    always #4 clk = ~clk;

    mdrx_node #(
        .OVERSAMPLE    (OS),
        .CLKS_PER_TICK (TPC),
        .NODE_ID       (ID),
        .EOC_CODE      (EOC)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .rxd        (rxd),
        .rx_byte    (rx_byte),
        .rx_is_addr (rx_is_addr),
        .rx_irq     (rx_irq),
        .frame_err  (frame_err),
        .selected   (selected)
    );

    always @(negedge clk) begin
        if (rx_irq) irq_cnt++;
        if (frame_err) err_cnt++;
        if (rx_irq && prev_irq) wide_irq++;
        prev_irq = rx_irq;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic flag, input logic stop_bit);
        hold(1'b0, BIT);
        for (int i = 0; i < 8; i++) hold(b[i], BIT);
        hold(flag, BIT);
        hold(stop_bit, BIT);
        hold(1'b1, 2 * BIT);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic       exp_sel;
        logic [7:0] d;
        logic [7:0] prev_b;
        logic       prev_a;
        int         i0, e0;

        repeat (5) @(negedge clk);
        // R9: reset state
        chk("R9 irq", int'(rx_irq), 0);
        chk("R9 err", int'(frame_err), 0);
        chk("R9 selected", int'(selected), 0);
        chk("R9 is_addr", int'(rx_is_addr), 0);
        chk("R9 byte", int'(rx_byte), 0);
        rst = 1'b0;
        hold(1'b1, 2 * BIT);

        exp_sel = 1'b0;
        for (int a = 0; a < 256; a++) begin
            i0 = irq_cnt;
            send(8'(a), 1'b1, 1'b1);
            chk("R3 addr irq count", irq_cnt - i0, 1);
            chk("R1 payload order", int'(rx_byte), a);
            chk("R3 addr flag", int'(rx_is_addr), 1);
            exp_sel = (8'(a) == ID);
            chk("R4 select", int'(selected), int'(exp_sel));

            d = 8'(a) ^ 8'h33;
            i0 = irq_cnt;
            prev_b = rx_byte;
            prev_a = rx_is_addr;
            send(d, 1'b0, 1'b1);
            if (exp_sel) begin
                chk("R5 data irq count", irq_cnt - i0, 1);
                chk("R5 data byte", int'(rx_byte), int'(d));
                chk("R5 data flag", int'(rx_is_addr), 0);
                if (d == EOC) exp_sel = 1'b0;
            end else begin
                chk("R6 no irq", irq_cnt - i0, 0);
                chk("R6 byte held", int'(rx_byte), int'(prev_b));
                chk("R6 flag held", int'(rx_is_addr), int'(prev_a));
            end
            chk("R4 R6 select after data", int'(selected), int'(exp_sel));
        end

        // R7: closing code
        send(ID, 1'b1, 1'b1);
        chk("R4 reselect", int'(selected), 1);
        i0 = irq_cnt;
        send(EOC, 1'b0, 1'b1);
        chk("R7 eoc irq", irq_cnt - i0, 1);
        chk("R7 eoc byte", int'(rx_byte), int'(EOC));
        chk("R7 deselected", int'(selected), 0);
        i0 = irq_cnt;
        send(8'h11, 1'b0, 1'b1);
        chk("R7 R6 data after eoc", irq_cnt - i0, 0);
        chk("R7 R6 byte held", int'(rx_byte), int'(EOC));

        // R8: framing errors keep selection
        send(ID, 1'b1, 1'b1);
        i0 = irq_cnt;
        e0 = err_cnt;
        send(8'h22, 1'b0, 1'b0);
        chk("R8 data err pulse", err_cnt - e0, 1);
        chk("R8 data no irq", irq_cnt - i0, 0);
        chk("R8 data sel kept", int'(selected), 1);
        i0 = irq_cnt;
        e0 = err_cnt;
        send(8'h00, 1'b1, 1'b0);
        chk("R8 addr err pulse", err_cnt - e0, 1);
        chk("R8 addr no irq", irq_cnt - i0, 0);
        chk("R8 addr sel kept", int'(selected), 1);
        chk("R8 byte held", int'(rx_byte), int'(ID));
        i0 = irq_cnt;
        send(8'h77, 1'b0, 1'b1);
        chk("R8 R5 data after err", irq_cnt - i0, 1);
        chk("R8 R5 byte after err", int'(rx_byte), 'h77);

        // R2: short glitch is not a start bit
        i0 = irq_cnt;
        e0 = err_cnt;
        hold(1'b0, BIT / 4);
        hold(1'b1, 20 * BIT);
        chk("R2 glitch no irq", irq_cnt - i0, 0);
        chk("R2 glitch no err", err_cnt - e0, 0);
        chk("R2 glitch sel kept", int'(selected), 1);

        // R10: interrupt width across whole run
        chk("R10 single cycle irq", wide_irq, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule